// File: doc/BRIEF.md
# Program Counter Sequencer

The block produces the address of the next instruction word for a small 8-bit controller core. It holds a 10-bit program counter, a four-entry return-address stack and a four-phase instruction-cycle timer. Each instruction cycle is four clocks long, T1 to T4. During T1 the block raises a fetch strobe with the address of the word to prefetch. At the end of T4 it takes the command that the decoder presented for the instruction now executing and moves the program counter.

A change of flow discards the word that was prefetched during that cycle. The next cycle is then marked as a dummy cycle by the `flush` output, and the decoder ignores the prefetched word. Commands can be a sequential step, a skip, a jump, a call, a return, a return from interrupt, or a write of the low address byte. Interrupt requests arrive already arbitrated, one external and one timer overflow. Each has a fixed vector. The return from interrupt moves the counter exactly as a return does, because interrupt masking is handled outside this block.

Top module: `pc_sequencer`

## Requirements
- R1: A low `rst_n` at a clock edge (synchronous) sets `fetch_addr` to 0x000, restarts the cycle at T1, sets `flush` to 1 and empties the stack (all entries 0, pointer 0).
- R2: An instruction cycle is 4 clocks. `fetch_stb` is high for exactly the first clock (T1), and the first clock after reset release is a T1. `phase_clk` is high during T1 and T2 and low during T3 and T4. `fetch_addr` changes only at the clock edge that ends T4.
- R3: Command code 0 (sequential) advances `fetch_addr` by one with `flush` 0. Code 7 acts as code 0. The address wraps from 0x3FF to 0x000.
- R4: Code 1 (skip) advances `fetch_addr` by one and sets `flush` to 1. The next executed word is therefore the skip's own address plus 2.
- R5: Code 2 (jump) loads all 10 bits of `imm` into `fetch_addr` and sets `flush` to 1.
- R6: Code 3 (call) pushes the current `fetch_addr` as the return address, loads `imm` and sets `flush` to 1.
- R7: Codes 4 (return) and 5 (return from interrupt) pop the stack into `fetch_addr` and set `flush` to 1.
- R8: Code 6 (low-byte write) replaces bits 7..0 of the address with `pcl_data` and keeps bits 9..8. It sets `flush` to 1.
- R9: An accepted external interrupt pushes the current `fetch_addr`, loads 0x004 and sets `flush`. It wins over a timer request at the same boundary.
- R10: An accepted timer interrupt pushes the current `fetch_addr`, loads 0x008 and sets `flush`.
- R11: An interrupt is accepted only at a boundary whose executing slot is sequential, meaning code 0 or 7 or a flush cycle. At any other boundary the command is carried out and the request waits.
- R12: During a cycle with `flush` at 1, the command input is ignored and treated as code 0.
- R13: The stack is circular with 4 entries. A fifth push overwrites the oldest entry, and a pop with no entries left returns whatever is in the slot below the pointer.
- R14: `pcl_rd` always equals bits 7..0 of `fetch_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_irq | input | 1 | External interrupt request, held until the vector is fetched |
| tmr_irq | input | 1 | Timer overflow interrupt request, held until the vector is fetched |
| cmd | input | 3 | Command of the executing instruction, sampled at the end of T4 |
| imm | input | 10 | Jump or call target |
| pcl_data | input | 8 | New low address byte for code 6 |
| fetch_addr | output | 10 | Address of the word fetched this cycle |
| fetch_stb | output | 1 | Fetch strobe, high during T1 |
| flush | output | 1 | Dummy cycle: the prefetched word is discarded |
| pcl_rd | output | 8 | Readable low address byte |
| phase_clk | output | 1 | Instruction-cycle clock, divide by 4 |

## Verification
A command or interrupt request that is held through a whole cycle takes effect at the edge ending its T4. The new address and `flush` are therefore visible from the next T1 onward, four edges after the inputs were applied in T1. The bench changes its inputs only on the falling edge that starts each T1 and holds them for four clocks. It compares `fetch_addr`, `flush` and `pcl_rd` against its model on every falling edge of the following cycle, so it sees both the stability inside the cycle and the single update at its end. The strobe and the divided clock are checked on each of the four falling edges against the phase count the bench keeps itself.

// File: rtl/pcseq_pkg.sv
// Shared command encoding for the program counter sequencer.
// Assumes the decoder drives one of these codes for the whole cycle.
package pcseq_pkg;
    typedef enum logic [2:0] {
        CMD_SEQ  = 3'd0,
        CMD_SKIP = 3'd1,
        CMD_JUMP = 3'd2,
        CMD_CALL = 3'd3,
        CMD_RET  = 3'd4,
        CMD_RETI = 3'd5,
        CMD_PCLW = 3'd6,
        CMD_RSVD = 3'd7
    } pc_cmd_e;
endpackage

// File: rtl/pcseq_phase.sv
// Instruction-cycle phase counter: runs T1..T(PHASES) and flags both ends.
// Assumes PHASES is a power of two of at least 2; reset restarts at T1.
module pcseq_phase #(
    parameter int PHASES = 4,
    localparam int PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase,
    output logic          cyc_start,
    output logic          cyc_end
);
    // Advance the phase every clock, wrapping after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + PW'(1);
    end

    assign cyc_start = (phase == '0);
    assign cyc_end   = (phase == PW'(PHASES - 1));
endmodule

// File: rtl/pcseq_stack.sv
// Circular return-address stack; a push onto a full stack overwrites the
// oldest entry. Assumes DEPTH is a power of two and push/pop never coincide.
module pcseq_stack #(
    parameter int DEPTH = 4,
    parameter int AW    = 10,
    localparam int SW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] top
);
    logic [AW-1:0] slot [DEPTH];
    logic [SW-1:0] sp;

    assign top = slot[sp - SW'(1)];

    // Move the pointer on push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= '0;
        else if (push) sp <= sp + SW'(1);
        else if (pop)  sp <= sp - SW'(1);
    end

    // One storage register per entry, written when the pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                      slot[i] <= '0;
            else if (push && sp == SW'(i))   slot[i] <= din;
        end
    end
endmodule

// File: rtl/pcseq_nextpc.sv
// Next-address selector: picks the following fetch address, the stack action
// and the dummy-cycle flag from the command, the interrupts and the flush state.
// Purely combinational; the caller applies the result only at cycle end.
module pcseq_nextpc
    import pcseq_pkg::*;
#(
    parameter int             AW      = 10,
    parameter int             DW      = 8,
    parameter logic [AW-1:0]  EXT_VEC = AW'(4),
    parameter logic [AW-1:0]  TMR_VEC = AW'(8)
) (
    input  logic [AW-1:0] pc,
    input  pc_cmd_e       cmd,
    input  logic          flush,
    input  logic          ext_irq,
    input  logic          tmr_irq,
    input  logic [AW-1:0] imm,
    input  logic [DW-1:0] pcl_data,
    input  logic [AW-1:0] stack_top,
    output logic [AW-1:0] nxt_pc,
    output logic          push,
    output logic          pop,
    output logic          nxt_flush
);
    pc_cmd_e exec;
    logic    idle_slot;

    assign exec      = flush ? CMD_SEQ : cmd;
    assign idle_slot = (exec == CMD_SEQ) || (exec == CMD_RSVD);

    // Priority select: external interrupt, timer interrupt, then command.
    always_comb begin
        nxt_pc    = pc + AW'(1);
        push      = 1'b0;
        pop       = 1'b0;
        nxt_flush = 1'b0;
        if (idle_slot && ext_irq) begin
            nxt_pc = EXT_VEC; push = 1'b1; nxt_flush = 1'b1;
        end else if (idle_slot && tmr_irq) begin
            nxt_pc = TMR_VEC; push = 1'b1; nxt_flush = 1'b1;
        end else begin
            case (exec)
                CMD_SKIP: nxt_flush = 1'b1;
                CMD_JUMP: begin nxt_pc = imm; nxt_flush = 1'b1; end
                CMD_CALL: begin nxt_pc = imm; push = 1'b1; nxt_flush = 1'b1; end
                CMD_RET,
                CMD_RETI: begin nxt_pc = stack_top; pop = 1'b1; nxt_flush = 1'b1; end
                CMD_PCLW: begin nxt_pc = {pc[AW-1:DW], pcl_data}; nxt_flush = 1'b1; end
                default:  nxt_flush = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pc_sequencer.sv
// Program counter sequencer top: phase timer, next-address select, return
// stack and the program counter itself. The counter and the flush flag move
// only at the edge ending T4. Assumes interrupt requests are pre-arbitrated
// and held until their vector is fetched.
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int AW     = 10,
    parameter int DW     = 8,
    parameter int DEPTH  = 4,
    parameter int PHASES = 4,
    localparam int PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_irq,
    input  logic          tmr_irq,
    input  logic [2:0]    cmd,
    input  logic [AW-1:0] imm,
    input  logic [DW-1:0] pcl_data,
    output logic [AW-1:0] fetch_addr,
    output logic          fetch_stb,
    output logic          flush,
    output logic [DW-1:0] pcl_rd,
    output logic          phase_clk
);
    logic [PW-1:0] phase_w;
    logic          cyc_start, cyc_end;
    logic [AW-1:0] pc_q, nxt_pc, stack_top;
    logic          flush_q, nxt_flush, push_w, pop_w;

    pcseq_phase #(.PHASES(PHASES)) u_phase (
        .clk(clk), .rst_n(rst_n), .phase(phase_w),
        .cyc_start(cyc_start), .cyc_end(cyc_end)
    );

    pcseq_nextpc #(.AW(AW), .DW(DW)) u_next (
        .pc(pc_q), .cmd(pc_cmd_e'(cmd)), .flush(flush_q),
        .ext_irq(ext_irq), .tmr_irq(tmr_irq), .imm(imm),
        .pcl_data(pcl_data), .stack_top(stack_top),
        .nxt_pc(nxt_pc), .push(push_w), .pop(pop_w), .nxt_flush(nxt_flush)
    );

    pcseq_stack #(.DEPTH(DEPTH), .AW(AW)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .push(push_w && cyc_end), .pop(pop_w && cyc_end),
        .din(pc_q), .top(stack_top)
    );

    // Commit the next address and dummy-cycle flag at the end of T4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            flush_q <= 1'b1;
        end else if (cyc_end) begin
            pc_q    <= nxt_pc;
            flush_q <= nxt_flush;
        end
    end

    assign fetch_addr = pc_q;
    assign flush      = flush_q;
    assign pcl_rd     = pc_q[DW-1:0];
    assign fetch_stb  = cyc_start;
    assign phase_clk  = (phase_w < PW'(PHASES / 2));
endmodule

// File: rtl/pcseq_checker.sv
// Property checker for pc_sequencer, attached by bind. Observes ports and the
// internal phase count; drives nothing.
module pcseq_checker #(
    parameter int AW = 10,
    parameter int DW = 8,
    parameter int PW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW-1:0] phase,
    input logic [2:0]    cmd,
    input logic [AW-1:0] imm,
    input logic [DW-1:0] pcl_data,
    input logic          ext_irq,
    input logic          tmr_irq,
    input logic [AW-1:0] fetch_addr,
    input logic          fetch_stb,
    input logic          flush
);
    logic last;
    logic seq_slot;
    assign last     = (phase == '1);
    assign seq_slot = flush || (cmd == 3'd0) || (cmd == 3'd7);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (fetch_addr == '0 && flush));

    assert_stable_mid_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(fetch_addr));

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stb |=> !fetch_stb);

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (last && seq_slot && !ext_irq && !tmr_irq)
        |=> (fetch_addr == $past(fetch_addr) + AW'(1) && !flush));

    assert_jump_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !flush && cmd == 3'd2) |=> (fetch_addr == $past(imm) && flush));

    assert_pcl_page_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !flush && cmd == 3'd6)
        |=> (fetch_addr == {$past(fetch_addr[AW-1:DW]), $past(pcl_data)}));

    assert_ext_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (last && seq_slot && ext_irq) |=> (fetch_addr == AW'(4) && flush));

    assert_tmr_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (last && seq_slot && !ext_irq && tmr_irq) |=> (fetch_addr == AW'(8) && flush));
endmodule

bind pc_sequencer pcseq_checker #(.AW(AW), .DW(DW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .phase(phase_w), .cmd(cmd), .imm(imm),
    .pcl_data(pcl_data), .ext_irq(ext_irq), .tmr_irq(tmr_irq),
    .fetch_addr(fetch_addr), .fetch_stb(fetch_stb), .flush(flush)
);

// File: tb/tb_pc_sequencer.sv
// Bench for pc_sequencer: directed corner cases, then seeded random commands,
// all compared with a behavioural model of the requirements.
module tb_pc_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_irq = 1'b0, tmr_irq = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [9:0] imm = '0;
    logic [7:0] pcl_data = '0;
    logic [9:0] fetch_addr;
    logic       fetch_stb, flush, phase_clk;
    logic [7:0] pcl_rd;

    int vectors = 0;
    int miscompares = 0;

    logic [9:0] m_pc;
    logic       m_flush;
    logic [9:0] m_stk [4];
    logic [1:0] m_sp;

    always #10 clk = ~clk;

    pc_sequencer dut (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .tmr_irq(tmr_irq),
        .cmd(cmd), .imm(imm), .pcl_data(pcl_data), .fetch_addr(fetch_addr),
        .fetch_stb(fetch_stb), .flush(flush), .pcl_rd(pcl_rd), .phase_clk(phase_clk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_pc = '0; m_flush = 1'b1; m_sp = '0;
        for (int i = 0; i < 4; i++) m_stk[i] = '0;
    endtask

    // Expected effect of one instruction-cycle boundary.
    task automatic model_step(input logic [2:0] c, input logic [9:0] im,
                              input logic [7:0] d, input logic e, input logic t);
        logic [2:0] x;
        logic       idle;
        x    = m_flush ? 3'd0 : c;
        idle = (x == 3'd0) || (x == 3'd7);
        if (idle && (e || t)) begin
            m_stk[m_sp] = m_pc; m_sp = m_sp + 2'd1;
            m_pc = e ? 10'h004 : 10'h008; m_flush = 1'b1;
        end else begin
            case (x)
                3'd1: begin m_pc = m_pc + 10'd1; m_flush = 1'b1; end
                3'd2: begin m_pc = im; m_flush = 1'b1; end
                3'd3: begin m_stk[m_sp] = m_pc; m_sp = m_sp + 2'd1; m_pc = im; m_flush = 1'b1; end
                3'd4, 3'd5: begin m_sp = m_sp - 2'd1; m_pc = m_stk[m_sp]; m_flush = 1'b1; end
                3'd6: begin m_pc = {m_pc[9:8], d}; m_flush = 1'b1; end
                default: begin m_pc = m_pc + 10'd1; m_flush = 1'b0; end
            endcase
        end
    endtask

    // One instruction cycle, entered at the falling edge inside T1.
    task automatic instr(input logic [2:0] c, input logic [9:0] im, input logic [7:0] d,
                         input logic e, input logic t, input string req);
        cmd = c; imm = im; pcl_data = d; ext_irq = e; tmr_irq = t;
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            chk(fetch_addr == m_pc, req, fetch_addr, m_pc);
            chk(flush == m_flush, req, flush, m_flush);
            chk(pcl_rd == m_pc[7:0], "R14", pcl_rd, m_pc[7:0]);
            chk(fetch_stb == (k == 0), "R2", fetch_stb, k == 0);
            chk(phase_clk == (k < 2), "R2", phase_clk, k < 2);
        end
        @(negedge clk);
        model_step(c, im, d, e, t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        vectors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [2:0] rc;
        logic       re, rt;
        void'($urandom(32'd5150));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, R12: command ignored in the flush cycle after reset
        chk(fetch_addr == 10'h000 && flush, "R1", fetch_addr, 0);
        instr(3'd2, 10'h155, 8'h00, 1'b0, 1'b0, "R12");
        instr(3'd0, 10'h000, 8'h00, 1'b0, 1'b0, "R3");
        // R4: skip discards the prefetched word
        instr(3'd1, 10'h000, 8'h00, 1'b0, 1'b0, "R4");
        instr(3'd0, 10'h000, 8'h00, 1'b0, 1'b0, "R4");
        instr(3'd0, 10'h000, 8'h00, 1'b0, 1'b0, "R4");
        // R5 and R3 wrap from 0x3FF
        instr(3'd2, 10'h3FE, 8'h00, 1'b0, 1'b0, "R5");
        instr(3'd0, 10'h000, 8'h00, 1'b0, 1'b0, "R5");
        instr(3'd7, 10'h000, 8'h00, 1'b0, 1'b0, "R3");
        instr(3'd0, 10'h000, 8'h00, 1'b0, 1'b0, "R3");
        // R8: low-byte write keeps the page
        instr(3'd2, 10'h2F0, 8'h00, 1'b0, 1'b0, "R5");
        instr(3'd0, 10'h000, 8'h00, 1'b0, 1'b0, "R8");
        instr(3'd6, 10'h000, 8'hA5, 1'b0, 1'b0, "R8");
        instr(3'd0, 10'h000, 8'h00, 1'b0, 1'b0, "R8");
        // R6, R13: five nested calls overflow the stack
        for (int i = 0; i < 5; i++) begin
            instr(3'd3, 10'h100 + 10'(i * 16), 8'h00, 1'b0, 1'b0, "R6");
            instr(3'd0, 10'h000, 8'h00, 1'b0, 1'b0, "R6");
        end
        // R7, R13: returns pop newest first, the fifth wraps
        for (int i = 0; i < 5; i++) begin
            instr((i % 2 == 0) ? 3'd4 : 3'd5, 10'h000, 8'h00, 1'b0, 1'b0, "R13");
            instr(3'd0, 10'h000, 8'h00, 1'b0, 1'b0, "R7");
        end
        // R9: external vector, and priority over timer
        instr(3'd0, 10'h000, 8'h00, 1'b1, 1'b0, "R9");
        instr(3'd0, 10'h000, 8'h00, 1'b0, 1'b0, "R9");
        instr(3'd5, 10'h000, 8'h00, 1'b0, 1'b0, "R7");
        instr(3'd0, 10'h000, 8'h00, 1'b1, 1'b1, "R9");
        instr(3'd0, 10'h000, 8'h00, 1'b0, 1'b1, "R10");
        // R10: timer vector taken in the flush cycle
        instr(3'd0, 10'h000, 8'h00, 1'b0, 1'b0, "R10");
        instr(3'd5, 10'h000, 8'h00, 1'b0, 1'b0, "R7");
        instr(3'd5, 10'h000, 8'h00, 1'b0, 1'b0, "R7");
        instr(3'd0, 10'h000, 8'h00, 1'b0, 1'b0, "R7");
        // R11: interrupt waits behind a jump, then is taken in the flush cycle
        instr(3'd2, 10'h0C0, 8'h00, 1'b1, 1'b0, "R11");
        instr(3'd2, 10'h0D0, 8'h00, 1'b1, 1'b0, "R11");
        instr(3'd0, 10'h000, 8'h00, 1'b0, 1'b0, "R11");
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            rc = 3'($urandom_range(0, 7));
            re = ($urandom_range(0, 15) == 0);
            rt = ($urandom_range(0, 15) == 0);
            instr(rc, 10'($urandom), 8'($urandom), re, rt, "R3");
        end
        // R1: reset in the middle of a run
        instr(3'd2, 10'h277, 8'h00, 1'b0, 1'b0, "R5");
        instr(3'd3, 10'h111, 8'h00, 1'b0, 1'b0, "R6");
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(fetch_addr == 10'h000, "R1", fetch_addr, 0);
        chk(flush == 1'b1, "R1", flush, 1);
        rst_n = 1'b1;
        model_reset();
        chk(fetch_stb == 1'b1, "R1", fetch_stb, 1);
        instr(3'd0, 10'h000, 8'h00, 1'b0, 1'b0, "R1");
        instr(3'd4, 10'h000, 8'h00, 1'b0, 1'b0, "R13");
        instr(3'd0, 10'h000, 8'h00, 1'b0, 1'b0, "R13");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule